// File: doc/BRIEF.md
# Dual-Vector Saturating Narrow Unit

This block narrows two wide vectors into one. Each vector holds signed 32-bit lanes. Every lane of both sources is clamped to the signed 16-bit range. The 16-bit results are packed into a single destination vector of the same total width. Lanes of the first source fill the low half of the destination and lanes of the second source fill the high half. Every destination lane is written on every execution, because the operation has no lane mask.

A small decoder examines the 32-bit instruction word that travels with the operands and reports three things:
- whether the fixed opcode bits match;
- the destination register index;
- the first register of the even/odd source pair.

A matching word that arrives while the feature enable is low is reported as undefined and writes nothing. Operands enter through a valid/ready handshake. The result, the decoded indices, the flags and a write strobe are registered and appear one cycle after the transfer is accepted. The vector width is a parameter: a multiple of 128 from 128 to 2048 bits.

Top module: `dvnarrow_unit`

## Requirements
- R1: Each signed 32-bit source lane above 32767 produces 0x7FFF, each lane below -32768 produces 0x8000, and any other lane produces its own low 16 bits.
- R2: With N = VEC_BITS/32, lane e of `src_a` goes to 16-bit destination lane e, and lane e of `src_b` goes to destination lane N+e. Source lane e occupies bits [32e+31:32e]; destination lane k occupies bits [16k+15:16k].
- R3: A word matches only when bits 31..10 equal 1100000100100011111000 and bit 5 is 0. Any other word sets `out_nomatch`, keeps `out_wr` low and drives `out_data` to zero.
- R4: `out_dst` equals instruction bits 4..0. `out_src` equals twice instruction bits 9..6, so it is always even, and the second source is `out_src`+1.
- R5: A matching word accepted while `feat_en` is 0 sets `out_undef`, keeps `out_wr` low and drives `out_data` to zero.
- R6: The outputs for an accepted transfer appear one cycle after it is accepted. `out_valid` rises with them, and `out_wr` is high exactly when the word matched and `feat_en` was 1.
- R7: `in_ready` is low while `out_valid` is high and `out_ready` is low. While the output is held in this way, all outputs stay unchanged.
- R8: After reset, `out_valid`, `out_wr`, `out_undef` and `out_nomatch` are 0, `out_data` is zero and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Feature enable; when low, matching words are undefined |
| in_valid | input | 1 | Operands and instruction word are present |
| in_ready | output | 1 | The unit can accept a transfer |
| instr | input | 32 | Instruction word |
| src_a | input | VEC_BITS | First source vector (even register) |
| src_b | input | VEC_BITS | Second source vector (odd register) |
| out_valid | output | 1 | The output register holds a result |
| out_ready | input | 1 | The consumer takes the output |
| out_wr | output | 1 | Write strobe: the destination should be written |
| out_undef | output | 1 | The word matched but the feature is disabled |
| out_nomatch | output | 1 | The fixed opcode bits differ |
| out_dst | output | 5 | Destination register index |
| out_src | output | 5 | First source register index (even) |
| out_data | output | VEC_BITS | Packed 16-bit results |

## Verification
Every result, flag and index is due one clock after the edge at which `in_valid` and `in_ready` are both high. The bench drives each transfer at a falling edge and drops `in_valid` at the next falling edge, after the accepting rising edge. It compares every output at that same falling edge, half a cycle after the register has loaded.

During a stall, the bench re-reads the outputs at the falling edges that follow. It expects them to be unchanged and expects `in_ready` to be low. When `out_ready` returns, the pending transfer is accepted at the next rising edge and is checked one falling edge later. The 128-bit and 512-bit widths run side by side on the same stimulus.

// File: rtl/dvn_pkg.sv
package dvn_pkg;

  // Fixed opcode bits 31..10 of the recognised instruction word
  localparam logic [21:0] OPC_HI = 22'b1100000100100011111000;

  // Clamp a signed 32-bit value into the signed 16-bit range
  function automatic logic [15:0] clamp16(input logic [31:0] v);
    logic fits;
    fits = (v[31:15] == {17{1'b0}}) || (v[31:15] == {17{1'b1}});
    if (fits)
      return v[15:0];
    else if (v[31])
      return 16'h8000;
    else
      return 16'h7FFF;
  endfunction

  // Register number of the first source from the 4-bit pair field
  function automatic logic [4:0] pair_base(input logic [3:0] f);
    return {f, 1'b0};
  endfunction

endpackage

// File: rtl/dvn_decode.sv
module dvn_decode
  import dvn_pkg::*;
(
  input  logic [31:0] word,
  input  logic        enable,
  output logic        hit,
  output logic        nomatch,
  output logic        undef,
  output logic [4:0]  dst,
  output logic [4:0]  src
);
  always_comb begin
    hit     = (word[31:10] == OPC_HI) && (word[5] == 1'b0);
    nomatch = !hit;
    undef   = hit && !enable;
    dst     = word[4:0];
    src     = pair_base(word[9:6]);
  end
endmodule

// File: rtl/dvn_lane_sat.sv
module dvn_lane_sat
  import dvn_pkg::*;
(
  input  logic [31:0] din,
  output logic [15:0] dout
);
  always_comb dout = clamp16(din);
endmodule

// File: rtl/dvn_pack.sv
module dvn_pack #(
  parameter int VEC_BITS = 128
) (
  input  logic [VEC_BITS-1:0] first,
  input  logic [VEC_BITS-1:0] second,
  output logic [VEC_BITS-1:0] packed_out
);
  localparam int NLANE = VEC_BITS / 32;
  localparam int HALF  = VEC_BITS / 2;

  for (genvar e = 0; e < NLANE; e++) begin : g_lane
    dvn_lane_sat u_lo (
      .din  (first[32*e +: 32]),
      .dout (packed_out[16*e +: 16])
    );
    dvn_lane_sat u_hi (
      .din  (second[32*e +: 32]),
      .dout (packed_out[HALF + 16*e +: 16])
    );
  end
endmodule

// File: rtl/dvnarrow_unit.sv
module dvnarrow_unit #(
  parameter int VEC_BITS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                feat_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [31:0]         instr,
  input  logic [VEC_BITS-1:0] src_a,
  input  logic [VEC_BITS-1:0] src_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_wr,
  output logic                out_undef,
  output logic                out_nomatch,
  output logic [4:0]          out_dst,
  output logic [4:0]          out_src,
  output logic [VEC_BITS-1:0] out_data
);
  // Internal events, named for the checker
  logic                accept;
  logic                dec_hit;
  logic                dec_nomatch;
  logic                dec_undef;
  logic                exec_ok;
  logic [4:0]          dec_dst;
  logic [4:0]          dec_src;
  logic [VEC_BITS-1:0] narrow_vec;

  dvn_decode u_dec (
    .word    (instr),
    .enable  (feat_en),
    .hit     (dec_hit),
    .nomatch (dec_nomatch),
    .undef   (dec_undef),
    .dst     (dec_dst),
    .src     (dec_src)
  );

  dvn_pack #(.VEC_BITS(VEC_BITS)) u_pack (
    .first      (src_a),
    .second     (src_b),
    .packed_out (narrow_vec)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign exec_ok  = dec_hit && feat_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wr      <= 1'b0;
      out_undef   <= 1'b0;
      out_nomatch <= 1'b0;
      out_dst     <= '0;
      out_src     <= '0;
      out_data    <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_wr      <= exec_ok;
      out_undef   <= dec_undef;
      out_nomatch <= dec_nomatch;
      out_dst     <= dec_dst;
      out_src     <= dec_src;
      out_data    <= exec_ok ? narrow_vec : '0;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
      out_wr      <= 1'b0;
    end
  end
endmodule

// File: rtl/dvnarrow_unit_chk.sv
module dvnarrow_unit_chk #(
  parameter int VEC_BITS = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                feat_en,
  input logic                in_ready,
  input logic [31:0]         instr,
  input logic [VEC_BITS-1:0] src_a,
  input logic [VEC_BITS-1:0] src_b,
  input logic                out_valid,
  input logic                out_ready,
  input logic                out_wr,
  input logic                out_undef,
  input logic                out_nomatch,
  input logic [4:0]          out_dst,
  input logic [4:0]          out_src,
  input logic [VEC_BITS-1:0] out_data,
  input logic                accept,
  input logic                dec_hit
);
  localparam int HALF = VEC_BITS / 2;

  initial begin
    assert_vl_param: assert (VEC_BITS % 128 == 0 && VEC_BITS >= 128 && VEC_BITS <= 2048);
  end

  // R1: a lane above the range clamps to the maximum
  assert_clamp_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_hit && feat_en && !src_a[31] && (src_a[30:15] != 16'h0000)
    |=> out_data[15:0] == 16'h7FFF);

  // R2: an in-range lane of the second source lands in the upper half
  assert_pack_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_hit && feat_en && (src_b[31:15] == 17'h0)
    |=> out_data[HALF +: 16] == $past(src_b[15:0]));

  assert_nomatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && instr[5] |=> out_nomatch && !out_wr && (out_data == '0));

  assert_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_dst == $past(instr[4:0])) && !out_src[0]
               && (out_src[4:1] == $past(instr[9:6])));

  assert_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_hit && !feat_en |=> out_undef && !out_wr && (out_data == '0));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_wr_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_valid && !out_undef && !out_nomatch);

  assert_stall_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dst)
                                && $stable(out_wr));
endmodule

bind dvnarrow_unit dvnarrow_unit_chk #(.VEC_BITS(VEC_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .feat_en     (feat_en),
  .in_ready    (in_ready),
  .instr       (instr),
  .src_a       (src_a),
  .src_b       (src_b),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_wr      (out_wr),
  .out_undef   (out_undef),
  .out_nomatch (out_nomatch),
  .out_dst     (out_dst),
  .out_src     (out_src),
  .out_data    (out_data),
  .accept      (accept),
  .dec_hit     (dec_hit)
);

// File: tb/dvnarrow_unit_tb.sv
module dvnarrow_unit_tb;
  localparam int WB = 512;
  localparam int NB = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          feat_en = 1'b1;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b1;
  logic [31:0]   instr = '0;
  logic [WB-1:0] va = '0, vb = '0;

  logic          rdy_w, ov_w, wr_w, ud_w, nm_w;
  logic [4:0]    dst_w, src_w;
  logic [WB-1:0] dat_w;
  logic          rdy_n, ov_n, wr_n, ud_n, nm_n;
  logic [4:0]    dst_n, src_n;
  logic [NB-1:0] dat_n;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dvnarrow_unit #(.VEC_BITS(WB)) u_dut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .in_valid(in_valid),
    .in_ready(rdy_w), .instr(instr), .src_a(va), .src_b(vb),
    .out_valid(ov_w), .out_ready(out_ready), .out_wr(wr_w), .out_undef(ud_w),
    .out_nomatch(nm_w), .out_dst(dst_w), .out_src(src_w), .out_data(dat_w));

  dvnarrow_unit #(.VEC_BITS(NB)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .in_valid(in_valid),
    .in_ready(rdy_n), .instr(instr), .src_a(va[NB-1:0]), .src_b(vb[NB-1:0]),
    .out_valid(ov_n), .out_ready(out_ready), .out_wr(wr_n), .out_undef(ud_n),
    .out_nomatch(nm_n), .out_dst(dst_n), .out_src(src_n), .out_data(dat_n));

  function automatic logic [15:0] ref_clamp(input logic [31:0] x);
    int s;
    s = $signed(x);
    if (s > 32767) return 16'h7FFF;
    if (s < -32768) return 16'h8000;
    return x[15:0];
  endfunction

  function automatic logic [WB-1:0] ref_pack(input logic [WB-1:0] a, input logic [WB-1:0] b,
                                             input int nl);
    logic [WB-1:0] r;
    r = '0;
    for (int e = 0; e < nl; e++) begin
      r[16*e +: 16]      = ref_clamp(a[32*e +: 32]);
      r[16*(nl+e) +: 16] = ref_clamp(b[32*e +: 32]);
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_word(input logic [3:0] zn, input logic [4:0] zd);
    return {22'b1100000100100011111000, zn, 1'b0, zd};
  endfunction

  function automatic logic [31:0] rnd_lane();
    int unsigned m;
    m = $urandom % 5;
    case (m)
      0: return $urandom;
      1: return 32'd32767 + ($urandom % 3) - 1;
      2: return 32'hFFFF8000 + ($urandom % 3) - 1;
      3: return {{17{1'b0}}, 15'($urandom)};
      default: return {{17{1'b1}}, 15'($urandom)};
    endcase
  endfunction

  task automatic chk(input string req, input logic [WB-1:0] act, input logic [WB-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare both widths against the expectation for the last accepted word
  task automatic check_all(input string req, input logic [31:0] w, input logic fe,
                           input logic [WB-1:0] a, input logic [WB-1:0] b);
    logic hit, ex;
    logic [WB-1:0] ew, en;
    hit = (w[31:10] == 22'b1100000100100011111000) && !w[5];
    ex  = hit && fe;
    ew  = ex ? ref_pack(a, b, WB/32) : '0;
    en  = ex ? ref_pack(a, b, NB/32) : '0;
    chk({req, " R6 valid"}, {ov_w, ov_n}, 2'b11);
    chk({req, " R6 wr"}, {wr_w, wr_n}, {ex, ex});
    chk({req, " R3 nomatch"}, {nm_w, nm_n}, {!hit, !hit});
    chk({req, " R5 undef"}, {ud_w, ud_n}, {hit && !fe, hit && !fe});
    chk({req, " R4 dst"}, {dst_w, dst_n}, {w[4:0], w[4:0]});
    chk({req, " R4 src"}, {src_w, src_n}, {w[9:6], 1'b0, w[9:6], 1'b0});
    chk({req, " R1 R2 data512"}, dat_w, ew);
    chk({req, " R1 R2 data128"}, {{(WB-NB){1'b0}}, dat_n}, en);
  endtask

  task automatic issue(input logic [31:0] w, input logic fe,
                       input logic [WB-1:0] a, input logic [WB-1:0] b);
    @(negedge clk);
    while (!rdy_w) @(negedge clk);
    instr = w; feat_en = fe; va = a; vb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic op(input string req, input logic [31:0] w, input logic fe,
                    input logic [WB-1:0] a, input logic [WB-1:0] b);
    issue(w, fe, a, b);
    check_all(req, w, fe, a, b);
  endtask

  function automatic logic [WB-1:0] rnd_vec();
    logic [WB-1:0] v;
    for (int e = 0; e < WB/32; e++) v[32*e +: 32] = rnd_lane();
    return v;
  endfunction

  initial begin
    int unsigned seed0;
    logic [WB-1:0] a, b, a2, b2, ea;
    seed0 = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R8 reset valid/wr", {ov_w, wr_w, ud_w, nm_w, rdy_w}, 5'b00001);
    chk("R8 reset data", dat_w, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after release", {ov_w, ov_n, rdy_w, rdy_n}, 4'b0011);

    // Directed corner lanes (R1, R2)
    a = '0; b = '0;
    a[31:0]   = 32'h00007FFF;  a[63:32]  = 32'hFFFF8000;
    a[95:64]  = 32'h00008000;  a[127:96] = 32'hFFFF7FFF;
    b[31:0]   = 32'h7FFFFFFF;  b[63:32]  = 32'h80000000;
    b[95:64]  = 32'h00001234;  b[127:96] = 32'hFFFFFFFE;
    for (int e = 4; e < WB/32; e++) begin
      a[32*e +: 32] = (e % 2) ? 32'h7FFFFFFF : 32'h80000000;
      b[32*e +: 32] = 32'(e * 1000 - 7000);
    end
    op("corner R1", mk_word(4'd3, 5'd17), 1'b1, a, b);
    op("corner swap R2", mk_word(4'd15, 5'd31), 1'b1, b, a);

    // Decode cases
    op("bit5 set R3", mk_word(4'd1, 5'd2) | 32'h20, 1'b1, a, b);
    op("opcode bit R3", mk_word(4'd1, 5'd2) ^ 32'h0100_0000, 1'b1, a, b);
    op("feature off R5", mk_word(4'd7, 5'd9), 1'b0, a, b);
    op("feature off bad word R3", mk_word(4'd7, 5'd9) | 32'h20, 1'b0, a, b);

    // Random stream (R1 R2 R4 R6)
    for (int i = 0; i < 150; i++) begin
      logic [31:0] w;
      w = mk_word(4'($urandom), 5'($urandom));
      if ($urandom % 8 == 0) w = w ^ (32'h1 << (10 + $urandom % 22));
      op("random", w, ($urandom % 6) != 0, rnd_vec(), rnd_vec());
    end

    // Backpressure (R7)
    @(negedge clk);
    out_ready = 1'b0;
    a = rnd_vec(); b = rnd_vec();
    op("stall first", mk_word(4'd5, 5'd6), 1'b1, a, b);
    ea = ref_pack(a, b, WB/32);
    a2 = rnd_vec(); b2 = rnd_vec();
    instr = mk_word(4'd9, 5'd1); va = a2; vb = b2; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 ready low while held", {rdy_w, rdy_n, ov_w}, 3'b001);
      chk("R7 data held", dat_w, ea);
      chk("R7 dst held", dst_w, 5'd6);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_all("R7 released", mk_word(4'd9, 5'd1), 1'b1, a2, b2);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule